// File: doc/BRIEF.md
# Two-Wire Byte Transfer Engine

This block runs one serial transfer at a time on an open-drain two-wire bus (a clock line and a data line) for a processor that programs it through three write ports and reads it through a data port and a status byte. A data write loads the shift register. A control write sets the role of the block (master or slave, transmitter or receiver) and the length of the next transfer. It also asks for a start, a repeated start or a stop condition. The engine then moves the bus lines one step for each pulse of an external quarter-bit tick and signals when it is done.

A bit group holds 1 to 8 data bits, shifted most significant bit first, with an optional extra acknowledge clock. In the acknowledge clock a transmitter releases the data line and samples the reply, and a receiver pulls the data line low. While the block holds the bus, a read of the data register returns the shift register contents and starts the next reception into the same register. That is how a byte stream is read, and a single released clock ends it with a negative acknowledge. If the block releases the data line and finds it low, it loses arbitration. It then withdraws from the bus and drops to slave.

Top module: `twi_byte_engine`

## Requirements
- R1: After reset the status byte reads 0x10, both lines are released (sdaOe = 0, sclOe = 0) and irq is 0. Status layout: bit 7 master, bit 6 transmitter, bit 5 busy, bit 4 done-not (low = transfer finished), bit 3 arbitration lost, bits 2:1 zero, bit 0 last sampled bit.
- R2: A control write with bit 7 (master) and bit 5 (busy) set, when the engine is idle, produces a start condition: SDA falls while SCL is high. Busy is set, and the shift register contents then go out most significant bit first.
- R3: The length is set by control bits 2:0. The value 0 gives 8 data bits and 1 to 7 give that many. Mode-register bit 6 (acknowledge mode, 1 after reset) adds one more clock.
- R4: When the last clock of a transfer ends, status bit 4 goes low and SCL stays driven low. irq is high exactly while status bit 4 is low and mode-register bit 7 is set.
- R5: Status bit 0 holds the data line level sampled on the last clock. A slave acknowledge reads 0 and a missing acknowledge reads 1.
- R6: A control write with bit 7 set and bit 5 clear, while the master holds the bus, produces a stop condition: SDA rises while SCL is high. Busy then clears and both lines are released.
- R7: A control write that sets bit 7 and bit 5 while the bus is held and master was clear produces a repeated start: SDA is released, SCL rises, and then SDA falls.
- R8: With control bit 6 clear (receiver), SDA is released on the data clocks and the bits are shifted into the data register. In acknowledge mode the block drives SDA low on the acknowledge clock.
- R9: While the bus is held as master, a data-register read presents the previous contents on dataOut in the read cycle and starts the next transfer. A data write starts a transfer of the byte just written.
- R10: With acknowledge mode off, a length of 1 and receiver role, exactly one clock is given with SDA released (negative acknowledge).
- R11: If the block releases SDA on a transmitted data bit and samples it low, it sets status bit 3, clears master and transmitter, releases both lines and lowers status bit 4.
- R12: SDA and SCL never change in the same cycle. A change of SDA while SCL is high happens only as a start or stop condition.
- R13: The drive outputs change only in the cycle after a sclTick pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| sclTick | input | 1 | Quarter-bit step pulse from the clock divider |
| wrCtrl | input | 1 | Write strobe for the control byte |
| wrData | input | 1 | Write strobe for the data register |
| wrMode | input | 1 | Write strobe for the mode byte (bit 7 irq enable, bit 6 acknowledge mode) |
| rdData | input | 1 | Read strobe for the data register |
| wrVal | input | 8 | Value for any write strobe |
| sdaIn | input | 1 | Sampled level of the data line |
| dataOut | output | 8 | Data register contents |
| statusOut | output | 8 | Status byte |
| irq | output | 1 | Completion interrupt request |
| sdaOe | output | 1 | Pull data line low when 1 |
| sclOe | output | 1 | Pull clock line low when 1 |

## Verification
A write or read strobe takes effect at the next rising edge. A line output moves at the edge on which a tick is seen, so a bit takes four ticks. The line output is set at the first tick, SCL rises at the second, the data line is sampled at the third and SCL falls at the fourth. The done flag falls at that fourth tick of the last clock, and a stop clears busy at its fourth tick. The bench drives strobes and samples outputs on falling edges. It polls the done and busy flags until they change, and only then compares counts of pulses, starts and stops seen on a bus model, the captured line bits, the status byte and dataOut.

// File: rtl/twi_pkg.sv
package twi_pkg;
  localparam int DATA_W = 8;
  localparam int CNT_W  = $clog2(DATA_W);
  localparam int LEN_W  = CNT_W + 1;
  localparam int REG_W  = 8;

  // control byte fields
  localparam int MST_POS  = 7;
  localparam int TRX_POS  = 6;
  localparam int BUSY_POS = 5;
  localparam int PIN_POS  = 4;
  // mode byte fields
  localparam int IRQEN_POS = 7;
  localparam int ACK_POS   = 6;

  typedef enum logic [2:0] {
    PH_IDLE, PH_START, PH_RSTART, PH_BIT, PH_STOP, PH_HOLD
  } phase_t;

  typedef struct packed {
    logic load;    // take wrVal into the shift register
    logic shift;   // shift one bus bit in at the sample point
    logic sample;  // capture the bus bit as last sampled bit
  } dp_strobe_t;
endpackage

// File: rtl/twi_shift.sv
module twi_shift
  import twi_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dp_strobe_t        strobe,
  input  logic [REG_W-1:0]  wrVal,
  input  logic              sdaIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataMsb,
  output logic              lastBit
);
  logic [DATA_W-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      lastBit  <= 1'b0;
    end else begin
      if (strobe.load)       shiftReg <= wrVal[DATA_W-1:0];
      else if (strobe.shift) shiftReg <= {shiftReg[DATA_W-2:0], sdaIn};
      if (strobe.sample)     lastBit  <= sdaIn;
    end
  end

  assign dataOut = shiftReg;
  assign dataMsb = shiftReg[DATA_W-1];
endmodule

// File: rtl/twi_ctrl.sv
module twi_ctrl
  import twi_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclTick,
  input  logic             wrCtrl,
  input  logic             wrData,
  input  logic             wrMode,
  input  logic             rdData,
  input  logic [REG_W-1:0] wrVal,
  input  logic             dataMsb,
  input  logic             sdaIn,
  output dp_strobe_t       strobe,
  output logic             sdaOe,
  output logic             sclOe,
  output logic             mst,
  output logic             trx,
  output logic             busy,
  output logic             pinN,
  output logic             arbLost,
  output logic             irqEn
);
  phase_t           phase;
  logic [1:0]       qtr;
  logic [LEN_W-1:0] bitsLeft;
  logic [CNT_W-1:0] cnt;
  logic             ackMode;

  function automatic logic [LEN_W-1:0] xferLen(input logic [CNT_W-1:0] c, input logic a);
    logic [LEN_W-1:0] n;
    n = (c == '0) ? LEN_W'(DATA_W) : LEN_W'(c);
    return n + LEN_W'(a);
  endfunction

  logic holding, settled, startReq, stopReq, launchReq;
  logic isAckBit, driveBit, samplePt, arbHit;

  assign holding   = (phase == PH_HOLD);
  assign settled   = (phase == PH_IDLE) || holding;
  assign startReq  = wrCtrl && wrVal[MST_POS] && wrVal[BUSY_POS] &&
                     ((phase == PH_IDLE) || (holding && !mst));
  assign stopReq   = wrCtrl && wrVal[MST_POS] && !wrVal[BUSY_POS] && holding && mst;
  assign launchReq = (wrData || rdData) && holding && mst;

  assign isAckBit  = ackMode && (bitsLeft == LEN_W'(1));
  // receiver pulls low on the acknowledge clock, transmitter releases it
  assign driveBit  = isAckBit ? trx : (trx ? dataMsb : 1'b1);
  assign samplePt  = sclTick && (phase == PH_BIT) && (qtr == 2'd2);
  assign arbHit    = samplePt && trx && !isAckBit && dataMsb && !sdaIn;

  assign strobe.load   = wrData && settled;
  assign strobe.shift  = samplePt && !isAckBit;
  assign strobe.sample = samplePt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      qtr      <= '0;
      bitsLeft <= '0;
      cnt      <= '0;
      ackMode  <= 1'b1;
      irqEn    <= 1'b0;
      mst      <= 1'b0;
      trx      <= 1'b0;
      busy     <= 1'b0;
      pinN     <= 1'b1;
      arbLost  <= 1'b0;
      sdaOe    <= 1'b0;
      sclOe    <= 1'b0;
    end else begin
      if (wrMode) begin
        irqEn   <= wrVal[IRQEN_POS];
        ackMode <= wrVal[ACK_POS];
      end
      if (wrCtrl && settled) begin
        mst <= wrVal[MST_POS];
        trx <= wrVal[TRX_POS];
        cnt <= wrVal[CNT_W-1:0];
        if (wrVal[PIN_POS]) pinN <= 1'b1;
      end

      if (startReq) begin
        phase    <= holding ? PH_RSTART : PH_START;
        qtr      <= '0;
        busy     <= 1'b1;
        arbLost  <= 1'b0;
        bitsLeft <= xferLen(wrVal[CNT_W-1:0], ackMode);
      end else if (stopReq) begin
        phase <= PH_STOP;
        qtr   <= '0;
      end else if (launchReq) begin
        phase    <= PH_BIT;
        qtr      <= '0;
        pinN     <= 1'b1;
        bitsLeft <= xferLen(cnt, ackMode);
      end else if (sclTick) begin
        qtr <= qtr + 2'd1;
        unique case (phase)
          PH_START: begin
            if (qtr == 2'd0) sdaOe <= 1'b1;
            if (qtr == 2'd2) sclOe <= 1'b1;
            if (qtr == 2'd3) phase <= PH_BIT;
          end
          PH_RSTART: begin
            if (qtr == 2'd0) sdaOe <= 1'b0;
            if (qtr == 2'd1) sclOe <= 1'b0;
            if (qtr == 2'd3) phase <= PH_START;
          end
          PH_STOP: begin
            if (qtr == 2'd0) sdaOe <= 1'b1;
            if (qtr == 2'd1) sclOe <= 1'b0;
            if (qtr == 2'd2) sdaOe <= 1'b0;
            if (qtr == 2'd3) begin
              phase <= PH_IDLE;
              busy  <= 1'b0;
            end
          end
          PH_BIT: begin
            if (qtr == 2'd0) sdaOe <= !driveBit;
            if (qtr == 2'd1) sclOe <= 1'b0;
            if (arbHit) begin
              sdaOe   <= 1'b0;
              sclOe   <= 1'b0;
              mst     <= 1'b0;
              trx     <= 1'b0;
              arbLost <= 1'b1;
              pinN    <= 1'b0;
              phase   <= PH_IDLE;
              qtr     <= '0;
            end
            if (qtr == 2'd3) begin
              sclOe <= 1'b1;
              if (bitsLeft == LEN_W'(1)) begin
                phase <= PH_HOLD;
                pinN  <= 1'b0;
              end else begin
                bitsLeft <= bitsLeft - LEN_W'(1);
              end
            end
          end
          default: qtr <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/twi_byte_engine.sv
module twi_byte_engine
  import twi_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclTick,
  input  logic              wrCtrl,
  input  logic              wrData,
  input  logic              wrMode,
  input  logic              rdData,
  input  logic [REG_W-1:0]  wrVal,
  input  logic              sdaIn,
  output logic [DATA_W-1:0] dataOut,
  output logic [REG_W-1:0]  statusOut,
  output logic              irq,
  output logic              sdaOe,
  output logic              sclOe
);
  dp_strobe_t strobe;
  logic dataMsb, lastBit;
  logic mst, trx, busy, pinN, arbLost, irqEn;

  twi_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclTick(sclTick),
    .wrCtrl(wrCtrl), .wrData(wrData), .wrMode(wrMode), .rdData(rdData),
    .wrVal(wrVal), .dataMsb(dataMsb), .sdaIn(sdaIn),
    .strobe(strobe), .sdaOe(sdaOe), .sclOe(sclOe),
    .mst(mst), .trx(trx), .busy(busy), .pinN(pinN),
    .arbLost(arbLost), .irqEn(irqEn)
  );

  twi_shift u_shift (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrVal(wrVal), .sdaIn(sdaIn),
    .dataOut(dataOut), .dataMsb(dataMsb), .lastBit(lastBit)
  );

  assign statusOut = {mst, trx, busy, pinN, arbLost, 2'b00, lastBit};
  assign irq       = irqEn && !pinN;
endmodule

// File: rtl/twi_byte_engine_chk.sv
module twi_byte_engine_chk (
  input logic       clk,
  input logic       rstN,
  input logic       sclTick,
  input logic [7:0] statusOut,
  input logic       irq,
  input logic       sdaOe,
  input logic       sclOe
);
  // R13
  line_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($changed(sdaOe) || $changed(sclOe)) |-> $past(sclTick));

  // R12
  sda_scl_split_chk: assert property (@(posedge clk) disable iff (!rstN)
    $changed(sdaOe) |-> $stable(sclOe));

  // R11
  arb_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusOut[3] |-> (!sdaOe && !sclOe));

  // R6
  stop_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statusOut[5]) |-> (!sdaOe && !sclOe));

  // R4
  irq_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> !statusOut[4]);

  // R4
  hold_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(statusOut[4]) && statusOut[7]) |-> sclOe);
endmodule

bind twi_byte_engine twi_byte_engine_chk u_chk (
  .clk(clk), .rstN(rstN), .sclTick(sclTick), .statusOut(statusOut),
  .irq(irq), .sdaOe(sdaOe), .sclOe(sclOe)
);

// File: tb/twi_byte_engine_bench.sv
module twi_byte_engine_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrCtrl = 1'b0, wrData = 1'b0, wrMode = 1'b0, rdData = 1'b0;
  logic [7:0] wrVal = '0;
  logic [7:0] dataOut, statusOut;
  logic irq, sdaOe, sclOe, sclTick, sdaIn;
  logic [1:0] tickDiv = '0;

  always #10 clk = ~clk;  // 50 MHz

  always @(negedge clk) tickDiv <= tickDiv + 2'd1;
  assign sclTick = (tickDiv == 2'd3);

  // bus model with a slave that pulls SDA low on chosen pulses
  logic [15:0] slaveMask = '0;
  int slaveIdx = 0, armIdx = 0, armCount = 0, armSeen = 0;
  logic slaveLow, sclBus, sdaBus;
  assign slaveLow = slaveMask[slaveIdx[3:0]];
  assign sclBus = !sclOe;
  assign sdaBus = !sdaOe && !slaveLow;
  assign sdaIn  = sdaBus;

  int pulseCnt = 0, startCnt = 0, stopCnt = 0;
  logic [15:0] capBits = '0;
  logic prevScl = 1'b1, prevSda = 1'b1;

  always @(negedge clk) begin
    if (prevScl && sclBus && prevSda && !sdaBus) begin
      startCnt <= startCnt + 1;
      slaveIdx <= 0;
    end
    if (prevScl && sclBus && !prevSda && sdaBus) stopCnt <= stopCnt + 1;
    if (!prevScl && sclBus) begin
      pulseCnt <= pulseCnt + 1;
      capBits  <= {capBits[14:0], sdaBus};
    end
    if (prevScl && !sclBus && slaveIdx < 15) slaveIdx <= slaveIdx + 1;
    if (armSeen != armCount) begin
      slaveIdx <= armIdx;
      armSeen  <= armCount;
    end
    prevScl <= sclBus;
    prevSda <= sdaBus;
  end

  twi_byte_engine u_twi_byte_engine (
    .clk(clk), .rstN(rstN), .sclTick(sclTick), .wrCtrl(wrCtrl), .wrData(wrData),
    .wrMode(wrMode), .rdData(rdData), .wrVal(wrVal), .sdaIn(sdaIn),
    .dataOut(dataOut), .statusOut(statusOut), .irq(irq), .sdaOe(sdaOe), .sclOe(sclOe)
  );

  int total = 0, bad = 0;

  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic strobeWr(input int which, input logic [7:0] v);
    wrVal = v;
    case (which)
      0: wrCtrl = 1'b1;
      1: wrData = 1'b1;
      default: wrMode = 1'b1;
    endcase
    @(negedge clk);
    wrCtrl = 1'b0; wrData = 1'b0; wrMode = 1'b0;
  endtask

  task automatic arm(input logic [15:0] mask, input int idx);
    slaveMask = mask;
    armIdx = idx;
    armCount++;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic waitDone(input string tag);
    for (int n = 0; n < 2000 && statusOut[4]; n++) @(negedge clk);
    checkEq({tag, " done flag low"}, statusOut[4], 1'b0);
  endtask

  task automatic waitFree(input string tag);
    for (int n = 0; n < 2000 && statusOut[5]; n++) @(negedge clk);
    checkEq({tag, " busy cleared"}, statusOut[5], 1'b0);
  endtask

  typedef struct packed {
    logic [7:0]  data;
    logic [2:0]  cnt;
    logic        ack;
    logic [15:0] mask;
    logic [3:0]  pulses;
    logic        last;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{8'hA5, 3'd0, 1'b1, 16'h0200, 4'd9, 1'b0},
    '{8'h3C, 3'd0, 1'b1, 16'h0000, 4'd9, 1'b1},
    '{8'hC0, 3'd3, 1'b0, 16'h0000, 4'd3, 1'b0},
    '{8'h80, 3'd1, 1'b1, 16'h0004, 4'd2, 1'b0},
    '{8'hFF, 3'd7, 1'b0, 16'h0000, 4'd7, 1'b1}
  };

  function automatic logic [15:0] expBus(input vec_t v);
    logic [15:0] r = '0;
    int nd = (v.cnt == 0) ? 8 : int'(v.cnt);
    for (int k = 1; k <= nd + int'(v.ack); k++)
      r = {r[14:0], ((k <= nd) ? v.data[8-k] : 1'b1) & !v.mask[k]};
    return r;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total + 1, bad + 1);
    $finish;
  end

  initial begin
    int p0, s0, t0;
    logic [15:0] m;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    checkEq("R1 status", statusOut, 8'h10);
    checkEq("R1 sdaOe", sdaOe, 1'b0);
    checkEq("R1 sclOe", sclOe, 1'b0);
    checkEq("R1 irq", irq, 1'b0);

    // table of transmit transfers: R2 R3 R5 R6
    for (int i = 0; i < 5; i++) begin
      strobeWr(2, {1'b0, VECS[i].ack, 6'b0});
      strobeWr(0, 8'h18);
      strobeWr(1, VECS[i].data);
      arm(VECS[i].mask, 0);
      p0 = pulseCnt; s0 = startCnt; t0 = stopCnt;
      strobeWr(0, {5'b11111, VECS[i].cnt});
      waitDone($sformatf("R4 vec%0d", i));
      checkEq($sformatf("R2 vec%0d start seen", i), startCnt - s0, 1);
      checkEq($sformatf("R3 vec%0d pulses", i), pulseCnt - p0, VECS[i].pulses);
      m = (16'h1 << VECS[i].pulses) - 16'h1;
      checkEq($sformatf("R2 vec%0d bits", i), capBits & m, expBus(VECS[i]));
      checkEq($sformatf("R5 vec%0d last bit", i), statusOut[0], VECS[i].last);
      checkEq($sformatf("R4 vec%0d scl held", i), sclOe, 1'b1);
      strobeWr(0, 8'hD8);
      waitFree($sformatf("R6 vec%0d", i));
      checkEq($sformatf("R6 vec%0d stop seen", i), stopCnt - t0, 1);
      checkEq($sformatf("R6 vec%0d lines", i), {sdaOe, sclOe}, 2'b00);
    end

    // R7 repeated start
    strobeWr(2, 8'h40);
    strobeWr(0, 8'h18);
    strobeWr(1, 8'hA0);
    arm(16'h0200, 0);
    strobeWr(0, 8'hF8);
    waitDone("R7 first");
    strobeWr(0, 8'h18);
    strobeWr(1, 8'hA1);
    p0 = pulseCnt; s0 = startCnt; t0 = stopCnt;
    strobeWr(0, 8'hF8);
    waitDone("R7 second");
    checkEq("R7 start seen", startCnt - s0, 1);
    checkEq("R7 no stop", stopCnt - t0, 0);
    checkEq("R7 pulses", pulseCnt - p0, 10);
    checkEq("R7 bits", capBits & 16'h01FF, 16'h0142);

    // R8 receive with own acknowledge, R4 irq
    strobeWr(2, 8'hC0);
    strobeWr(0, 8'hB8);
    arm(16'h012C, 1);
    p0 = pulseCnt;
    rdData = 1'b1; @(negedge clk); rdData = 1'b0;
    waitDone("R8 rx");
    checkEq("R8 pulses", pulseCnt - p0, 9);
    checkEq("R8 bits", capBits & 16'h01FF, 16'h012C);
    checkEq("R8 data", dataOut, 8'h96);
    checkEq("R8 own ack", statusOut[0], 1'b0);
    checkEq("R4 irq", irq, 1'b1);

    // R9 R10 double-buffered read with negative acknowledge
    strobeWr(2, 8'h80);
    strobeWr(0, 8'hA9);
    arm(16'h0000, 1);
    p0 = pulseCnt;
    checkEq("R9 old byte on read", dataOut, 8'h96);
    rdData = 1'b1; @(negedge clk); rdData = 1'b0;
    checkEq("R9 launch clears done", statusOut[4], 1'b1);
    waitDone("R10 nack");
    checkEq("R10 pulses", pulseCnt - p0, 1);
    checkEq("R10 released bit", capBits[0], 1'b1);
    checkEq("R10 last bit", statusOut[0], 1'b1);
    checkEq("R8 shifted in", dataOut, 8'h2D);
    t0 = stopCnt;
    strobeWr(0, 8'hD8);
    waitFree("R6 after read");
    checkEq("R6 stop after read", stopCnt - t0, 1);

    // R11 arbitration loss on third bit
    strobeWr(2, 8'h40);
    strobeWr(0, 8'h18);
    strobeWr(1, 8'hFF);
    arm(16'h0008, 0);
    p0 = pulseCnt;
    strobeWr(0, 8'hF8);
    waitDone("R11");
    checkEq("R11 arb flag", statusOut[3], 1'b1);
    checkEq("R11 roles cleared", statusOut[7:6], 2'b00);
    checkEq("R11 pulses", pulseCnt - p0, 3);
    checkEq("R11 lines", {sdaOe, sclOe}, 2'b00);
    arm(16'h0000, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule